// File: doc/BRIEF.md
# Universal Latched/Registered Bus Transceiver

This block is a non-inverting, two-way bus transceiver between an A side and a B side, each 18 bits wide. The A-to-B path and the B-to-A path each have their own storage cell and their own drive enable. At run time a control pin sets whether the cell is a transparent latch or a register that captures on the falling edge of that direction's pin clock. While the latch control is high, data flows straight through. While it is low, the stored word is driven, and it changes only when a high-to-low transition of the pin clock is seen.

Tri-state pins are split into separate input, output and enable vectors, so the logic stays synthesizable. An enable vector is all ones when that side drives and all zeros when it floats. The two enable pins have opposite polarity: the A-to-B enable is active high and the B-to-A enable is active low. Everything runs on one system clock. Each pin clock is sampled once per system cycle, and a falling edge is detected by comparing the current sample with the previous one. A synchronous active-high reset stands in for power-up. It empties both storage cells and keeps both sides floating.

Top module: `xcvr_univ`

## Requirements
- R1: While `ab_le` is 1, `b_out` equals `a_in` in the same cycle, bit for bit and without inversion, across all 18 bits.
- R2: While `ab_le` is 0 and the sampled `ab_ck` has the same level as in the previous system cycle (steady high or steady low), `b_out` keeps its stored value whatever `a_in` does.
- R3: While `ab_le` is 0, a system clock edge at which `ab_ck` is sampled 0 after having been sampled 1 at the edge before loads `a_in` into storage. `b_out` shows the new value from that edge on.
- R4: While `ab_le` is 0, a low-to-high change of `ab_ck` loads nothing, and `b_out` is unchanged.
- R5: `b_oe` is all ones when `ab_en` is 1 and all zeros when `ab_en` is 0, outside reset. The level of `ab_en` has no effect on the value of `b_out`.
- R6: The B-to-A path behaves as R1 to R4 describe, using `ba_le`, `ba_ck`, `b_in` and `a_out`, and it is independent of the A-to-B path.
- R7: `a_oe` is all ones when `ba_en_n` is 0 and all zeros when `ba_en_n` is 1, outside reset. The B-to-A enable is active low.
- R8: While `rst` is 1, `a_oe` and `b_oe` are all zeros whatever the enable pins are. At the first clock edge with `rst` high, both stored words become zero and both previous pin-clock samples become low. The enables follow their pins from the first clock edge with `rst` low.
- R9: Each system clock edge at which a latch control is 1 loads the passing input into storage. After the control falls, the output keeps the last word that passed through, until a falling pin-clock edge loads a new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up stand-in) |
| a_in | input | 18 | Word seen on the A pins |
| a_out | output | 18 | Word driven toward the A pins |
| a_oe | output | 18 | Per-bit drive enable for the A pins |
| b_in | input | 18 | Word seen on the B pins |
| b_out | output | 18 | Word driven toward the B pins |
| b_oe | output | 18 | Per-bit drive enable for the B pins |
| ab_le | input | 1 | A-to-B latch control, 1 = pass through |
| ab_ck | input | 1 | A-to-B pin clock, captures on falling edge |
| ab_en | input | 1 | A-to-B drive enable, active high |
| ba_le | input | 1 | B-to-A latch control, 1 = pass through |
| ba_ck | input | 1 | B-to-A pin clock, captures on falling edge |
| ba_en_n | input | 1 | B-to-A drive enable, active low |

## Verification
The hardest case to reach from the ports is telling a captured falling edge apart from a held level or from an ignored rising edge. Each of these needs the pin clock held at a level across more than one system cycle, with the latch control low and the input data changing in between. The stimulus table raises a pin clock and holds it high for a second row, then drops it and holds it low, putting new data on the input at every row. Only the row with the falling transition may change the output. Mixed rows then run one path transparent while the other path sees a rising edge, and put the two enables at opposite settings, to show that the paths are independent and that the enables have opposite polarity.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_W = 18;

  // Polarity of a direction's drive-enable pin
  typedef enum logic {
    EN_ACT_HIGH = 1'b0,
    EN_ACT_LOW  = 1'b1
  } en_pol_e;
endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= pin;
  end

  assign fall = prev_q & ~pin;
endmodule

// File: rtl/xcvr_store_cell.sv
module xcvr_store_cell #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic         fall,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] held
);
  logic [W-1:0] store_q;

  always_ff @(posedge clk) begin
    if (rst)            store_q <= '0;
    else if (le | fall) store_q <= din;
  end

  assign held = store_q;
  assign dout = le ? din : store_q;

  // R2
  hold_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!le && !fall) |=> $stable(store_q));

  // R3
  fall_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!le && fall) |=> (store_q == $past(din)));

  // R9
  pass_load_chk: assert property (@(posedge clk) disable iff (rst)
    le |=> (store_q == $past(din)));
endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir
  import xcvr_pkg::*;
#(
  parameter int unsigned W   = XCVR_W,
  parameter en_pol_e     POL = EN_ACT_HIGH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic         pclk,
  input  logic         en_pin,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] oe
);
  logic         fall;
  logic [W-1:0] held;
  logic         en_act;
  logic         live_q;

  xcvr_edge_det edge_i (
    .clk  (clk),
    .rst  (rst),
    .pin  (pclk),
    .fall (fall)
  );

  xcvr_store_cell #(.W(W)) cell_i (
    .clk  (clk),
    .rst  (rst),
    .le   (le),
    .fall (fall),
    .din  (din),
    .dout (dout),
    .held (held)
  );

  generate
    if (POL == EN_ACT_LOW) begin : g_low
      assign en_act = ~en_pin;
    end else begin : g_high
      assign en_act = en_pin;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  assign oe = {W{live_q & en_act}};

  // R4
  rise_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!le && $rose(pclk)) |=> $stable(held));
endmodule

// File: rtl/xcvr_univ.sv
module xcvr_univ
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         ab_le,
  input  logic         ab_ck,
  input  logic         ab_en,
  input  logic         ba_le,
  input  logic         ba_ck,
  input  logic         ba_en_n
);
  xcvr_dir #(.W(W), .POL(EN_ACT_HIGH)) fwd_i (
    .clk    (clk),
    .rst    (rst),
    .le     (ab_le),
    .pclk   (ab_ck),
    .en_pin (ab_en),
    .din    (a_in),
    .dout   (b_out),
    .oe     (b_oe)
  );

  xcvr_dir #(.W(W), .POL(EN_ACT_LOW)) rev_i (
    .clk    (clk),
    .rst    (rst),
    .le     (ba_le),
    .pclk   (ba_ck),
    .en_pin (ba_en_n),
    .din    (b_in),
    .dout   (a_out),
    .oe     (a_oe)
  );

  // R5
  b_side_pol_chk: assert property (@(posedge clk) disable iff (rst)
    (b_oe != '0) |-> ab_en);

  // R7
  a_side_pol_chk: assert property (@(posedge clk) disable iff (rst)
    (a_oe != '0) |-> !ba_en_n);

  // R8
  reset_float_chk: assert property (@(posedge clk)
    rst |=> ((a_oe == '0) && (b_oe == '0)));
endmodule

// File: tb/xcvr_univ_tb_top.sv
`timescale 1ns/1ps
module xcvr_univ_tb_top;
  localparam int W = 18;
  localparam int NROW = 11;

  typedef struct packed {
    logic ab_le; logic ab_ck; logic ab_en; logic [17:0] a;
    logic ba_le; logic ba_ck; logic ba_en_n; logic [17:0] b;
    logic [17:0] exp_b; logic exp_boe;
    logic [17:0] exp_a; logic exp_aoe;
  } vec_t;

  // rows: each is driven at a falling clk edge and checked 1 ns after the next rising edge
  localparam vec_t TBL [NROW] = '{
    '{1'b1,1'b0,1'b1,18'h12345, 1'b1,1'b0,1'b0,18'h0ABCD, 18'h12345,1'b1, 18'h0ABCD,1'b1},
    '{1'b0,1'b0,1'b1,18'h3FFFF, 1'b0,1'b0,1'b0,18'h2AAAA, 18'h12345,1'b1, 18'h0ABCD,1'b1},
    '{1'b0,1'b1,1'b1,18'h15555, 1'b0,1'b1,1'b0,18'h1F0F0, 18'h12345,1'b1, 18'h0ABCD,1'b1},
    '{1'b0,1'b1,1'b1,18'h00F0F, 1'b0,1'b1,1'b0,18'h3C3C3, 18'h12345,1'b1, 18'h0ABCD,1'b1},
    '{1'b0,1'b0,1'b1,18'h2468A, 1'b0,1'b0,1'b0,18'h13579, 18'h2468A,1'b1, 18'h13579,1'b1},
    '{1'b0,1'b0,1'b1,18'h11111, 1'b0,1'b0,1'b0,18'h22222, 18'h2468A,1'b1, 18'h13579,1'b1},
    '{1'b0,1'b0,1'b0,18'h11111, 1'b0,1'b0,1'b1,18'h22222, 18'h2468A,1'b0, 18'h13579,1'b0},
    '{1'b1,1'b0,1'b1,18'h0FFFF, 1'b0,1'b1,1'b0,18'h33333, 18'h0FFFF,1'b1, 18'h13579,1'b1},
    '{1'b0,1'b0,1'b1,18'h1ABCD, 1'b0,1'b0,1'b0,18'h2BCDE, 18'h0FFFF,1'b1, 18'h2BCDE,1'b1},
    '{1'b0,1'b0,1'b1,18'h1ABCD, 1'b0,1'b0,1'b1,18'h2BCDE, 18'h0FFFF,1'b1, 18'h2BCDE,1'b0},
    '{1'b0,1'b0,1'b0,18'h1ABCD, 1'b0,1'b0,1'b0,18'h2BCDE, 18'h0FFFF,1'b0, 18'h2BCDE,1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic ab_le = 1'b0, ab_ck = 1'b0, ab_en = 1'b1;
  logic ba_le = 1'b0, ba_ck = 1'b0, ba_en_n = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  xcvr_univ #(.W(W)) dut_i (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_le(ab_le), .ab_ck(ab_ck), .ab_en(ab_en),
    .ba_le(ba_le), .ba_ck(ba_ck), .ba_en_n(ba_en_n)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string row_tag(input int i);
    case (i)
      0:       return "R1 pass-through";
      1:       return "R9 hold after pass";
      2:       return "R4 rise ignored";
      3:       return "R2 steady high";
      4:       return "R3 falling capture";
      5:       return "R2 steady low";
      6:       return "R5 R7 data kept with enables off";
      7:       return "R1 R4 mixed paths";
      8:       return "R9 R3 mixed paths";
      default: return "R5 R7 split enables";
    endcase
  endfunction

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  initial begin
    // reset with enables requesting drive and latches closed
    a_in = 18'h3FFFF; b_in = 18'h15555;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 b_oe in reset", b_oe, '0);
    chk("R8 a_oe in reset", a_oe, '0);
    chk("R8 b_out cleared", b_out, '0);
    chk("R8 a_out cleared", a_out, '0);
    @(negedge clk);
    rst = 1'b0;
    settle();
    chk("R8 R5 b_oe after release", b_oe, '1);
    chk("R8 R7 a_oe after release", a_oe, '1);

    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      ab_le = TBL[i].ab_le; ab_ck = TBL[i].ab_ck; ab_en = TBL[i].ab_en; a_in = TBL[i].a;
      ba_le = TBL[i].ba_le; ba_ck = TBL[i].ba_ck; ba_en_n = TBL[i].ba_en_n; b_in = TBL[i].b;
      settle();
      chk($sformatf("%s b_out row %0d", row_tag(i), i), b_out, TBL[i].exp_b);
      chk($sformatf("R6 %s a_out row %0d", row_tag(i), i), a_out, TBL[i].exp_a);
      chk($sformatf("R5 b_oe row %0d", i), b_oe, {W{TBL[i].exp_boe}});
      chk($sformatf("R7 a_oe row %0d", i), a_oe, {W{TBL[i].exp_aoe}});
    end

    // R1 same-cycle pass: change input mid-cycle with latch open
    @(negedge clk);
    ab_le = 1'b1; ba_le = 1'b1; a_in = 18'h2A5A5; b_in = 18'h05A5A;
    #1;
    chk("R1 same-cycle b_out", b_out, 18'h2A5A5);
    chk("R6 same-cycle a_out", a_out, 18'h05A5A);

    // mid-run reset with enables requesting drive
    @(negedge clk);
    ab_le = 1'b0; ba_le = 1'b0; ab_ck = 1'b0; ba_ck = 1'b0;
    ab_en = 1'b1; ba_en_n = 1'b0; rst = 1'b1;
    settle();
    chk("R8 mid-run b_oe", b_oe, '0);
    chk("R8 mid-run a_oe", a_oe, '0);
    chk("R8 mid-run b_out", b_out, '0);
    chk("R8 mid-run a_out", a_out, '0);
    @(negedge clk);
    rst = 1'b0;
    settle();
    chk("R8 re-release b_oe", b_oe, '1);
    chk("R8 re-release a_oe", a_oe, '1);
    chk("R8 stored stays zero", b_out, '0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule